// File: doc/BRIEF.md
# Startup Supply Current-Source Sequencer

This block is the digital sequencer behind a high-voltage startup current source in an offline switching controller. It sees only registered comparator flags: the high-voltage pin above its minimum, the supply above the turn-on level, and the supply below the restart, inhibit, turn-off and logic-reset levels. It also sees a thermal-shutdown flag. From these flags it decides whether the source conducts and at which current. It also decides when the controller may start switching and when it must stop.

The source charges the supply capacitor until the turn-on level is reached. It then keeps the supply between the restart and turn-on levels by switching on and off, so the controller can live on the high-voltage pin alone. Near zero supply it charges at a reduced current. After a fresh reset, the first turn-on crossing only completes the initial charge, and switching begins on the second crossing. A turn-off dip that lasts longer than a blanking time stops the controller and clears the overload fault timer. The next turn-on crossing then restarts switching at once. Thermal shutdown forces the source off, and its release begins a fresh startup. A supply below the logic-reset level clears all state asynchronously.

Top module: `hvStartSeq`

## Requirements
- R1: While reset is held and in the cycles after it is released with all flags low, srcEn, srcHiCur, startPulse, stopEvt and faultTmrClr are all 0.
- R2: The source conducts only while the high-voltage-pin flag is high. It stops once that flag falls and conducts again once the flag returns, provided charging is still wanted. Every output reacts to an input change on the third rising clock edge after it.
- R3: The source stops on each rising crossing of the turn-on flag. It stays off while the supply sits between the restart and turn-on levels, and it turns on again once the restart flag rises.
- R4: While it conducts, srcHiCur is 0 when the inhibit flag is high (low current) and 1 otherwise (high current).
- R5: The source does not re-enable at the restart level while the high-voltage-pin flag is low or thermal shutdown is active.
- R6: After reset or thermal release, the first turn-on crossing produces no start. The next crossing produces a one-cycle startPulse. Crossings while already running produce none.
- R7: The turn-off flag acts only after it has stayed high for BLANK_TICKS ticks of a 1 MHz tick, derived as CLK_PER_TICK clocks. Shorter dips have no effect on stopEvt or faultTmrClr.
- R8: A blanked turn-off while running gives stopEvt and faultTmrClr together for one cycle and stops the controller. The very next turn-on crossing then issues startPulse, without a second crossing.
- R9: Thermal shutdown turns the source off and, if running, pulses stopEvt. On release the source is enabled again, and a full two-crossing startup follows.
- R10: While supBelowReset is high, every output is 0 at once, without waiting for a clock edge. After it falls, the block behaves as after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hvAboveMin | input | 1 | High-voltage pin above its minimum operating level |
| supAboveOn | input | 1 | Supply above the turn-on level |
| supBelowRestart | input | 1 | Supply below the restart level |
| supBelowInhibit | input | 1 | Supply below the inhibit (near-zero) level |
| supBelowOff | input | 1 | Supply below the turn-off level |
| supBelowReset | input | 1 | Supply below the logic-reset level; clears all state asynchronously |
| thermShut | input | 1 | Thermal shutdown active |
| srcEn | output | 1 | Startup current source enable |
| srcHiCur | output | 1 | 1 selects high current, 0 selects low current |
| startPulse | output | 1 | One-cycle controller start event |
| stopEvt | output | 1 | One-cycle controller stop event |
| faultTmrClr | output | 1 | One-cycle overload fault-timer clear |

## Verification
On every cycle, the assertions check these relations:
- the source is never enabled without the high-voltage flag three edges earlier, nor while thermal shutdown has propagated;
- a start pulse lasts one cycle and follows a real rising crossing;
- a fault-timer clear always comes with a stop, and only after a turn-off flag that persisted;
- a supply below the logic-reset level silences every output.

Only the bench's scenarios can show the history-dependent behaviour. This covers the ignored first crossing, the hysteresis between restart and turn-on, the exact blanking length against short and long dips, the immediate restart after a turn-off, and the fresh two-crossing startup after thermal release.

// File: rtl/hvss_pkg.sv
package hvss_pkg;

  // Synchronised flag positions inside the raw flag vector
  localparam int F_HV   = 0;
  localparam int F_ON   = 1;
  localparam int F_RST  = 2;
  localparam int F_INH  = 3;
  localparam int F_OFF  = 4;
  localparam int F_TSD  = 5;
  localparam int NUM_FLAGS = 6;

  typedef enum logic [1:0] {
    SRC_STOP = 2'd0,
    SRC_LOW  = 2'd1,
    SRC_HIGH = 2'd2,
    SRC_OFF  = 2'd3
  } srcState_t;

  // Datapath -> control
  typedef struct packed {
    logic hvOk;
    logic belowRestart;
    logic belowInhibit;
    logic therm;
    logic onRise;
    logic offEvt;
  } sense_t;

  // Control -> datapath strobes
  typedef struct packed {
    logic blankClr;
  } dpCmd_t;

endpackage

// File: rtl/hvss_sync.sv
module hvss_sync (
  input  logic clk,
  input  logic arstN,
  input  logic din,
  output logic dout
);
  logic stage1;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      stage1 <= 1'b0;
      dout   <= 1'b0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/hvss_dp.sv
module hvss_dp
  import hvss_pkg::*;
#(
  parameter int CLK_PER_TICK = 125,
  parameter int BLANK_TICKS  = 10
) (
  input  logic                 clk,
  input  logic                 arstN,
  input  logic [NUM_FLAGS-1:0] rawFlags,
  input  dpCmd_t               cmd,
  output sense_t               sense
);
  localparam int TICK_W  = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam int BLANK_W = $clog2(BLANK_TICKS + 1);
  localparam logic [TICK_W-1:0]  TICK_LAST  = TICK_W'(CLK_PER_TICK - 1);
  localparam logic [BLANK_W-1:0] BLANK_LAST = BLANK_W'(BLANK_TICKS - 1);

  logic [NUM_FLAGS-1:0] syncFlags;

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_sync
    hvss_sync u_sync (
      .clk  (clk),
      .arstN(arstN),
      .din  (rawFlags[i]),
      .dout (syncFlags[i])
    );
  end

  // Turn-on crossing detector
  logic onPrev;
  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) onPrev <= 1'b0;
    else        onPrev <= syncFlags[F_ON];
  end

  // Free-running microsecond tick
  logic [TICK_W-1:0] tickCnt;
  logic              tickNow;
  assign tickNow = (tickCnt == TICK_LAST);

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN)       tickCnt <= '0;
    else if (tickNow) tickCnt <= '0;
    else              tickCnt <= tickCnt + 1'b1;
  end

  // Turn-off persistence blanking
  logic [BLANK_W-1:0] blankCnt;
  logic               blankDone;
  logic               offEvtQ;

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      blankCnt  <= '0;
      blankDone <= 1'b0;
      offEvtQ   <= 1'b0;
    end else begin
      offEvtQ <= 1'b0;
      if (cmd.blankClr || !syncFlags[F_OFF]) begin
        blankCnt  <= '0;
        blankDone <= 1'b0;
      end else if (tickNow && !blankDone) begin
        if (blankCnt == BLANK_LAST) begin
          blankDone <= 1'b1;
          offEvtQ   <= 1'b1;
        end else begin
          blankCnt <= blankCnt + 1'b1;
        end
      end
    end
  end

  always_comb begin
    sense.hvOk         = syncFlags[F_HV];
    sense.belowRestart = syncFlags[F_RST];
    sense.belowInhibit = syncFlags[F_INH];
    sense.therm        = syncFlags[F_TSD];
    sense.onRise       = syncFlags[F_ON] && !onPrev;
    sense.offEvt       = offEvtQ;
  end
endmodule

// File: rtl/hvss_ctrl.sv
module hvss_ctrl
  import hvss_pkg::*;
(
  input  logic   clk,
  input  logic   arstN,
  input  sense_t sense,
  output dpCmd_t cmd,
  output logic   srcEn,
  output logic   srcHiCur,
  output logic   startPulse,
  output logic   stopEvt,
  output logic   faultTmrClr
);
  srcState_t srcQ, srcN;
  logic chgQ, chgN;      // charging wanted (hysteresis latch)
  logic armQ, armN;      // initial charge completed
  logic runQ, runN;      // controller switching
  logic startN, stopN, clrN;

  assign cmd.blankClr = !runQ || sense.therm;

  always_comb begin
    srcN   = srcQ;
    chgN   = chgQ;
    armN   = armQ;
    runN   = runQ;
    startN = 1'b0;
    stopN  = 1'b0;
    clrN   = 1'b0;
    if (sense.therm) begin
      srcN  = SRC_OFF;
      chgN  = 1'b1;
      armN  = 1'b0;
      runN  = 1'b0;
      stopN = runQ;
    end else if (srcQ == SRC_OFF) begin
      srcN = SRC_STOP;
    end else begin
      if (sense.offEvt) begin
        runN  = 1'b0;
        armN  = 1'b1;
        chgN  = 1'b1;
        stopN = 1'b1;
        clrN  = 1'b1;
      end else if (sense.onRise) begin
        chgN = 1'b0;
        if (!armQ) begin
          armN = 1'b1;
        end else if (!runQ) begin
          runN   = 1'b1;
          startN = 1'b1;
        end
      end else if (sense.belowRestart) begin
        chgN = 1'b1;
      end
      if (chgN && sense.hvOk)
        srcN = sense.belowInhibit ? SRC_LOW : SRC_HIGH;
      else
        srcN = SRC_STOP;
    end
  end

  always_ff @(posedge clk or negedge arstN) begin
    if (!arstN) begin
      srcQ        <= SRC_STOP;
      chgQ        <= 1'b1;
      armQ        <= 1'b0;
      runQ        <= 1'b0;
      startPulse  <= 1'b0;
      stopEvt     <= 1'b0;
      faultTmrClr <= 1'b0;
    end else begin
      srcQ        <= srcN;
      chgQ        <= chgN;
      armQ        <= armN;
      runQ        <= runN;
      startPulse  <= startN;
      stopEvt     <= stopN;
      faultTmrClr <= clrN;
    end
  end

  assign srcEn    = (srcQ == SRC_LOW) || (srcQ == SRC_HIGH);
  assign srcHiCur = (srcQ == SRC_HIGH);
endmodule

// File: rtl/hvStartSeq.sv
module hvStartSeq
  import hvss_pkg::*;
#(
  parameter int CLK_PER_TICK = 125,
  parameter int BLANK_TICKS  = 10
) (
  input  logic clk,
  input  logic rstN,
  input  logic hvAboveMin,
  input  logic supAboveOn,
  input  logic supBelowRestart,
  input  logic supBelowInhibit,
  input  logic supBelowOff,
  input  logic supBelowReset,
  input  logic thermShut,
  output logic srcEn,
  output logic srcHiCur,
  output logic startPulse,
  output logic stopEvt,
  output logic faultTmrClr
);
  logic                 arstN;
  logic [NUM_FLAGS-1:0] rawFlags;
  sense_t               sense;
  dpCmd_t               cmd;

  assign arstN = rstN && !supBelowReset;

  always_comb begin
    rawFlags        = '0;
    rawFlags[F_HV]  = hvAboveMin;
    rawFlags[F_ON]  = supAboveOn;
    rawFlags[F_RST] = supBelowRestart;
    rawFlags[F_INH] = supBelowInhibit;
    rawFlags[F_OFF] = supBelowOff;
    rawFlags[F_TSD] = thermShut;
  end

  hvss_dp #(
    .CLK_PER_TICK(CLK_PER_TICK),
    .BLANK_TICKS (BLANK_TICKS)
  ) u_dp (
    .clk     (clk),
    .arstN   (arstN),
    .rawFlags(rawFlags),
    .cmd     (cmd),
    .sense   (sense)
  );

  hvss_ctrl u_ctrl (
    .clk        (clk),
    .arstN      (arstN),
    .sense      (sense),
    .cmd        (cmd),
    .srcEn      (srcEn),
    .srcHiCur   (srcHiCur),
    .startPulse (startPulse),
    .stopEvt    (stopEvt),
    .faultTmrClr(faultTmrClr)
  );
endmodule

// File: rtl/hvss_chk.sv
module hvss_chk (
  input logic clk,
  input logic rstN,
  input logic hvAboveMin,
  input logic supAboveOn,
  input logic supBelowOff,
  input logic supBelowReset,
  input logic thermShut,
  input logic srcEn,
  input logic startPulse,
  input logic stopEvt,
  input logic faultTmrClr
);
  logic [2:0] sinceRst;
  logic       warm;
  logic       chkRstN;

  assign chkRstN = rstN && !supBelowReset;
  assign warm    = (sinceRst == 3'd7);

  always_ff @(posedge clk or negedge chkRstN) begin
    if (!chkRstN)   sinceRst <= 3'd0;
    else if (!warm) sinceRst <= sinceRst + 3'd1;
  end

  AST_EN_NEEDS_HV: assert property (@(posedge clk) disable iff (!chkRstN)
    warm && srcEn |-> $past(hvAboveMin, 3)); // R2

  AST_THERM_FORCES_OFF: assert property (@(posedge clk) disable iff (!chkRstN)
    warm && $past(thermShut, 3) |-> !srcEn); // R5

  AST_START_ON_CROSSING: assert property (@(posedge clk) disable iff (!chkRstN)
    warm && startPulse |-> $past(supAboveOn, 3) && !$past(supAboveOn, 4)); // R6

  AST_START_SINGLE: assert property (@(posedge clk) disable iff (!chkRstN)
    startPulse |=> !startPulse); // R6

  AST_CLR_WITH_STOP: assert property (@(posedge clk) disable iff (!chkRstN)
    faultTmrClr |-> stopEvt && !startPulse); // R8

  AST_OFF_PERSISTED: assert property (@(posedge clk) disable iff (!chkRstN)
    warm && faultTmrClr |-> $past(supBelowOff, 4) && $past(supBelowOff, 5)); // R7

  AST_POR_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    supBelowReset |-> !srcEn && !startPulse && !stopEvt && !faultTmrClr); // R10
endmodule

bind hvStartSeq hvss_chk u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .hvAboveMin   (hvAboveMin),
  .supAboveOn   (supAboveOn),
  .supBelowOff  (supBelowOff),
  .supBelowReset(supBelowReset),
  .thermShut    (thermShut),
  .srcEn        (srcEn),
  .startPulse   (startPulse),
  .stopEvt      (stopEvt),
  .faultTmrClr  (faultTmrClr)
);

// File: tb/sim_hvStartSeq.sv
module sim_hvStartSeq;
  localparam int TICKDIV = 125;
  localparam int BLANKN  = 10;

  // supply levels
  localparam int LV_ZERO = 0;  // below inhibit, turn-off and restart
  localparam int LV_LOW  = 1;  // below turn-off and restart
  localparam int LV_RST  = 2;  // below restart only
  localparam int LV_MID  = 3;  // between restart and turn-on
  localparam int LV_ON   = 4;  // above turn-on

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN = 1'b0;
  logic hvAboveMin = 0, supAboveOn = 0, supBelowRestart = 0, supBelowInhibit = 0;
  logic supBelowOff = 0, supBelowReset = 0, thermShut = 0;
  logic srcEn, srcHiCur, startPulse, stopEvt, faultTmrClr;

  hvStartSeq #(.CLK_PER_TICK(TICKDIV), .BLANK_TICKS(BLANKN)) u0 (
    .clk(clk), .rstN(rstN), .hvAboveMin(hvAboveMin), .supAboveOn(supAboveOn),
    .supBelowRestart(supBelowRestart), .supBelowInhibit(supBelowInhibit),
    .supBelowOff(supBelowOff), .supBelowReset(supBelowReset), .thermShut(thermShut),
    .srcEn(srcEn), .srcHiCur(srcHiCur), .startPulse(startPulse),
    .stopEvt(stopEvt), .faultTmrClr(faultTmrClr));

  int total = 0, bad = 0;
  int startCnt = 0, stopCnt = 0, clrCnt = 0;
  bit finished = 0;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  wire mRst = !rstN || supBelowReset;
  int  dly1 [6];
  int  dly2 [6];
  int  lastOn, tcount, bcount, bdone, offPend;
  int  mState;       // 0 stop, 1 low, 2 high, 3 thermal off
  int  wantChg, seenFirst, running;
  int  mStart, mStop, mClr;

  always @(posedge clk or posedge mRst) begin
    if (mRst) begin
      foreach (dly1[k]) begin dly1[k] = 0; dly2[k] = 0; end
      lastOn = 0; tcount = 0; bcount = 0; bdone = 0; offPend = 0;
      mState = 0; wantChg = 1; seenFirst = 0; running = 0;
      mStart = 0; mStop = 0; mClr = 0;
    end else begin
      int hv, rs, inh, off, tsd, rise, tick, clr, newOff, chg;
      hv = dly2[0]; rs = dly2[2]; inh = dly2[3]; off = dly2[4]; tsd = dly2[5];
      rise = (dly2[1] != 0 && lastOn == 0);
      tick = (tcount == TICKDIV - 1);
      clr  = (running == 0) || (tsd != 0);
      // control, from present state
      mStart = 0; mStop = 0; mClr = 0;
      if (tsd) begin
        mStop = running; mState = 3; wantChg = 1; seenFirst = 0; running = 0;
      end else if (mState == 3) begin
        mState = 0;
      end else begin
        chg = wantChg;
        if (offPend) begin
          running = 0; seenFirst = 1; chg = 1; mStop = 1; mClr = 1;
        end else if (rise) begin
          chg = 0;
          if (!seenFirst) seenFirst = 1;
          else if (!running) begin running = 1; mStart = 1; end
        end else if (rs) chg = 1;
        wantChg = chg;
        mState = (chg && hv) ? (inh ? 1 : 2) : 0;
      end
      // blanking, from present state
      newOff = 0;
      if (clr || !off) begin bcount = 0; bdone = 0; end
      else if (tick && !bdone) begin
        if (bcount == BLANKN - 1) begin bdone = 1; newOff = 1; end
        else bcount++;
      end
      offPend = newOff;
      tcount = tick ? 0 : tcount + 1;
      lastOn = dly2[1];
      dly2 = dly1;
      dly1[0] = hvAboveMin; dly1[1] = supAboveOn; dly1[2] = supBelowRestart;
      dly1[3] = supBelowInhibit; dly1[4] = supBelowOff; dly1[5] = thermShut;
    end
  end

  // per-cycle comparison and pulse bookkeeping
  always @(negedge clk) begin
    if (rstN && !finished) begin
      check("R2 srcEn vs model", srcEn, (mState == 1 || mState == 2));
      check("R4 srcHiCur vs model", srcHiCur, (mState == 2));
      check("R6 startPulse vs model", startPulse, mStart);
      check("R8 stopEvt vs model", stopEvt, mStop);
      check("R8 faultTmrClr vs model", faultTmrClr, mClr);
      startCnt += startPulse;
      stopCnt  += stopEvt;
      clrCnt   += faultTmrClr;
    end
  end

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic setSup(input int lv);
    supAboveOn      = (lv == LV_ON);
    supBelowRestart = (lv <= LV_RST);
    supBelowOff     = (lv <= LV_LOW);
    supBelowInhibit = (lv == LV_ZERO);
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    // R1: reset state
    setSup(LV_ZERO);
    waitCyc(5);
    check("R1 srcEn in reset", srcEn, 0);
    check("R1 startPulse in reset", startPulse, 0);
    rstN = 1'b1;
    waitCyc(6);
    check("R1 srcEn after release, hv low", srcEn, 0);
    check("R1 stopEvt after release", stopEvt, 0);

    // R2/R4: charge at low current near zero
    hvAboveMin = 1'b1;
    waitCyc(2);
    check("R2 latency: not yet enabled", srcEn, 0);
    waitCyc(1);
    check("R2 enabled on third edge", srcEn, 1);
    check("R4 low current near zero", srcHiCur, 0);
    setSup(LV_MID);
    waitCyc(5);
    check("R4 high current above inhibit", srcHiCur, 1);

    // R6: first crossing only ends initial charge
    setSup(LV_ON);
    waitCyc(6);
    check("R3 source off at turn-on", srcEn, 0);
    check("R6 no start on first crossing", startCnt, 0);

    // R3 hysteresis
    setSup(LV_MID);
    waitCyc(6);
    check("R3 stays off between levels", srcEn, 0);
    setSup(LV_RST);
    waitCyc(6);
    check("R3 re-enabled at restart", srcEn, 1);

    // R5/R2: hv pin low blocks the source
    hvAboveMin = 1'b0;
    waitCyc(6);
    check("R5 no source while hv low", srcEn, 0);
    hvAboveMin = 1'b1;
    waitCyc(6);
    check("R2 source back with hv", srcEn, 1);

    // R6: second crossing starts
    setSup(LV_ON);
    waitCyc(6);
    check("R6 start on second crossing", startCnt, 1);
    setSup(LV_MID);
    waitCyc(3);
    setSup(LV_ON);
    waitCyc(6);
    check("R6 no start while running", startCnt, 1);

    // R7: short dip ignored
    setSup(LV_LOW);
    waitCyc(500);
    setSup(LV_MID);
    waitCyc(6);
    check("R7 short dip no stop", stopCnt, 0);
    check("R7 short dip no fault clear", clrCnt, 0);

    // R8: long dip stops, quick restart
    setSup(LV_LOW);
    waitCyc(2000);
    check("R8 stop after blanking", stopCnt, 1);
    check("R8 fault timer cleared", clrCnt, 1);
    setSup(LV_ON);
    waitCyc(6);
    check("R8 restart on next crossing", startCnt, 2);

    // R9: thermal shutdown
    thermShut = 1'b1;
    waitCyc(6);
    check("R9 stop on thermal", stopCnt, 2);
    check("R9 source off in thermal", srcEn, 0);
    setSup(LV_RST);
    waitCyc(6);
    check("R5 no restart in thermal", srcEn, 0);
    thermShut = 1'b0;
    waitCyc(8);
    check("R9 source enabled after thermal", srcEn, 1);
    setSup(LV_ON);
    waitCyc(6);
    check("R9 first crossing after thermal ignored", startCnt, 2);
    setSup(LV_RST);
    waitCyc(6);
    setSup(LV_ON);
    waitCyc(6);
    check("R9 second crossing starts", startCnt, 3);

    // R10: asynchronous logic reset
    setSup(LV_RST);
    waitCyc(6);
    check("R10 precondition source on", srcEn, 1);
    @(negedge clk); #2;
    supBelowReset = 1'b1;
    #1;
    check("R10 immediate clear", srcEn, 0);
    waitCyc(5);
    check("R10 held clear", srcEn, 0);
    supBelowReset = 1'b0;
    waitCyc(6);
    check("R10 restarts after release", srcEn, 1);
    setSup(LV_ON);
    waitCyc(6);
    check("R10 first crossing after release ignored", startCnt, 3);

    waitCyc(4);
    finishRun();
  end
endmodule